// File: doc/BRIEF.md
# Lockstep compare fail-silent gate

This block sits after two identical, deterministic processing channels, a worker and a checker, that run in lockstep. Each channel presents a result word with a valid strobe. When both strobes are high in the same cycle the gate compares the words. If they are equal, it passes the worker's word to the plant-facing output register. On the first disagreement the gate drops into a latched silent state. There it drives a configurable safe word and refuses to pass either channel's value. Two healthy channels are needed to run (2oo2). One faulty channel is enough to silence the output.

A strobe that arrives alone is allowed some skew. If its partner does not arrive within a bounded number of cycles, the gate treats this as a disagreement. Once silent, the gate recovers only through reset, or through a maintenance clear that is honoured on a cycle where the two channels agree.

The comparator and the output switch are safety-relevant, so they are exercised on a fixed schedule. On one cycle in every self-test period, the gate feeds the comparator a deliberately corrupted operand and confirms that it reports a difference. The plant does not see this: the output holds its last value for that cycle. If the comparator fails to flag the injected difference, a separate sticky comparator-fault flag is raised and the output goes to the safe word.

Top module: `lsc_gate`

## Requirements
- R1: When both valid strobes are high in the same (non-test) cycle and the words are equal, in the running state `safe_word` takes the worker's word at the next clock edge.
- R2: A cycle with neither strobe high leaves `safe_word` unchanged.
- R3: When both strobes are high and the words differ, at the next edge `silent` becomes 1, `err_pulse` is 1 for that one cycle, and `safe_word` equals `SAFE_VAL`.
- R4: While `silent` is 1, equal words without `maint_clr` keep `silent` at 1 and `safe_word` at `SAFE_VAL`.
- R5: `maint_clr` returns the gate to running (`silent` 0, `safe_word` = worker word) only on a cycle with an agreeing compare. A clear with no compare, or with disagreeing words, is ignored.
- R6: A strobe from only one channel is tolerated for up to `SKEW_MAX` consecutive cycles. The (`SKEW_MAX`+1)-th consecutive lone-strobe cycle counts as a disagreement, with the consequences of R3. A cycle with both strobes restarts the count.
- R7: Counting the first clock edge after reset release as cycle 0, cycles `TEST_PERIOD`-1, 2·`TEST_PERIOD`-1, … are self-test cycles. On them the channel strobes and words are ignored, `safe_word` holds, and `err_pulse` stays 0.
- R8: A self-test in which the comparator does not report the injected difference sets the sticky `cmp_fault`, sets `silent`, and drives `SAFE_VAL`. With a working comparator, `cmp_fault` stays 0.
- R9: While `rst` is high, at each edge `safe_word` becomes `SAFE_VAL` and `silent`, `err_pulse` and `cmp_fault` become 0. The skew and self-test counters restart from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wrk_vld | input | 1 | Worker result valid strobe |
| wrk_word | input | W | Worker result word |
| chk_vld | input | 1 | Checker result valid strobe |
| chk_word | input | W | Checker result word |
| maint_clr | input | 1 | Maintenance clear of the silent state |
| safe_word | output | W | Registered plant-facing output |
| err_pulse | output | 1 | One-cycle flag for a detected channel disagreement |
| silent | output | 1 | Sticky fail-silent status |
| cmp_fault | output | 1 | Sticky flag: the self-test found the comparator dead |

## Verification
Every result of this block is registered. A stimulus present during clock edge n shows up on `safe_word`, `err_pulse`, `silent` and `cmp_fault` right after that edge. A self-test cycle shows up as a held output after the same edge. The bench drives inputs on the falling edge and samples on the next falling edge, so each check looks at exactly one edge's effect. The bench places its vectors by cycle index from reset release. This puts the skew timeout on the third lone cycle and the self-test on index 15 of a 16-cycle period, which is where the expected values are written.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    // Gate state: running passes agreed words, silent drives the safe word.
    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_SILENT = 1'b1
    } lsc_state_e;

    // Per-cycle decision bundle produced from the comparator and skew tracker.
    typedef struct packed {
        logic fault;      // real disagreement or skew timeout
        logic agree;      // aligned pair with equal words
        logic test_fail;  // self-test cycle where comparator saw no difference
    } lsc_evt_t;

    // Counter width able to hold values 0 .. n-1.
    function automatic int unsigned cnt_bits(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // An agreeing pair may drive the output when running, or when clearing.
    function automatic logic may_pass(lsc_state_e st, logic clr);
        return (st == ST_RUN) || clr;
    endfunction

endpackage

// File: rtl/lsc_cmp.sv
module lsc_cmp #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         differ
);
    always_comb begin
        differ = |(op_a ^ op_b);
    end
endmodule

// File: rtl/lsc_skew.sv
module lsc_skew #(
    parameter int unsigned SKEW_MAX = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic freeze,
    input  logic vld_a,
    input  logic vld_b,
    output logic timeout
);
    import lsc_pkg::*;

    localparam int unsigned CW = cnt_bits(SKEW_MAX + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SKEW_MAX);

    logic [CW-1:0] lone_cnt;
    logic          lone;

    always_comb begin
        lone    = vld_a ^ vld_b;
        timeout = !freeze && lone && (lone_cnt == LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lone_cnt <= '0;
        end else if (!freeze) begin
            if (lone && (lone_cnt != LIMIT)) begin
                lone_cnt <= lone_cnt + 1'b1;
            end else begin
                lone_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/lsc_selftest.sv
module lsc_selftest #(
    parameter int unsigned TEST_PERIOD = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic differ,
    output logic test_hit,
    output logic test_fail
);
    import lsc_pkg::*;

    localparam int unsigned TW = cnt_bits(TEST_PERIOD);
    localparam logic [TW-1:0] LAST = TW'(TEST_PERIOD - 1);

    logic [TW-1:0] tick;

    always_comb begin
        test_hit  = (tick == LAST);
        test_fail = test_hit && !differ;
    end

    always_ff @(posedge clk) begin
        if (rst || test_hit) begin
            tick <= '0;
        end else begin
            tick <= tick + 1'b1;
        end
    end
endmodule

// File: rtl/lsc_gate.sv
module lsc_gate #(
    parameter int unsigned   W           = 32,
    parameter int unsigned   SKEW_MAX    = 4,
    parameter int unsigned   TEST_PERIOD = 1024,
    parameter logic [W-1:0]  SAFE_VAL    = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wrk_vld,
    input  logic [W-1:0] wrk_word,
    input  logic         chk_vld,
    input  logic [W-1:0] chk_word,
    input  logic         maint_clr,
    output logic [W-1:0] safe_word,
    output logic         err_pulse,
    output logic         silent,
    output logic         cmp_fault
);
    import lsc_pkg::*;

    localparam logic [W-1:0] INJ_MASK = '1;

    lsc_state_e   state;
    logic [W-1:0] out_q;
    logic         err_q;
    logic         cmpf_q;

    logic         st_hit;
    logic         st_fail;
    logic         skew_to;
    logic         differ;
    logic         pair;
    logic [W-1:0] cmp_b;
    lsc_evt_t     evt;

    // During a self-test the second operand is the worker word corrupted.
    always_comb begin
        cmp_b = st_hit ? (wrk_word ^ INJ_MASK) : chk_word;
        pair  = wrk_vld && chk_vld && !st_hit;
    end

    lsc_cmp #(.W(W)) u_cmp (
        .op_a   (wrk_word),
        .op_b   (cmp_b),
        .differ (differ)
    );

    lsc_skew #(.SKEW_MAX(SKEW_MAX)) u_skew (
        .clk     (clk),
        .rst     (rst),
        .freeze  (st_hit),
        .vld_a   (wrk_vld),
        .vld_b   (chk_vld),
        .timeout (skew_to)
    );

    lsc_selftest #(.TEST_PERIOD(TEST_PERIOD)) u_test (
        .clk       (clk),
        .rst       (rst),
        .differ    (differ),
        .test_hit  (st_hit),
        .test_fail (st_fail)
    );

    always_comb begin
        evt.fault     = (pair && differ) || skew_to;
        evt.agree     = pair && !differ;
        evt.test_fail = st_fail;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_RUN;
            out_q  <= SAFE_VAL;
            err_q  <= 1'b0;
            cmpf_q <= 1'b0;
        end else begin
            err_q <= evt.fault;
            if (evt.test_fail) begin
                state  <= ST_SILENT;
                cmpf_q <= 1'b1;
                out_q  <= SAFE_VAL;
            end else if (evt.fault) begin
                state <= ST_SILENT;
                out_q <= SAFE_VAL;
            end else if (evt.agree && may_pass(state, maint_clr)) begin
                state  <= ST_RUN;
                cmpf_q <= 1'b0;
                out_q  <= wrk_word;
            end
        end
    end

    always_comb begin
        safe_word = out_q;
        err_pulse = err_q;
        silent    = (state == ST_SILENT);
        cmp_fault = cmpf_q;
    end
endmodule

// File: rtl/lsc_gate_chk.sv
module lsc_gate_chk #(
    parameter int unsigned  W        = 32,
    parameter logic [W-1:0] SAFE_VAL = '0
) (
    input logic         clk,
    input logic         rst,
    input logic         wrk_vld,
    input logic [W-1:0] wrk_word,
    input logic         chk_vld,
    input logic [W-1:0] chk_word,
    input logic         maint_clr,
    input logic [W-1:0] safe_word,
    input logic         err_pulse,
    input logic         silent,
    input logic         cmp_fault,
    input logic         test_cyc
);
    a_r1_agree_passes: assert property (@(posedge clk) disable iff (rst)
        (wrk_vld && chk_vld && wrk_word == chk_word && !test_cyc && !silent)
        |=> (safe_word == $past(wrk_word)));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!wrk_vld && !chk_vld && !test_cyc) |=> $stable(safe_word));

    a_r3_mismatch_silences: assert property (@(posedge clk) disable iff (rst)
        (wrk_vld && chk_vld && wrk_word != chk_word && !test_cyc)
        |=> (silent && err_pulse && safe_word == SAFE_VAL));

    a_r3_err_implies_silent: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> silent);

    a_r4_silent_sticky: assert property (@(posedge clk) disable iff (rst)
        (silent && !(maint_clr && wrk_vld && chk_vld && wrk_word == chk_word && !test_cyc))
        |=> silent);

    a_r4_silent_drives_safe: assert property (@(posedge clk) disable iff (rst)
        silent |-> (safe_word == SAFE_VAL));

    a_r7_test_invisible: assert property (@(posedge clk) disable iff (rst)
        test_cyc |=> (!err_pulse && ($stable(safe_word) || cmp_fault)));

    a_r8_cmpfault_silent: assert property (@(posedge clk) disable iff (rst)
        cmp_fault |-> silent);

    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> (safe_word == SAFE_VAL && !silent && !err_pulse && !cmp_fault));
endmodule

bind lsc_gate lsc_gate_chk #(.W(W), .SAFE_VAL(SAFE_VAL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wrk_vld   (wrk_vld),
    .wrk_word  (wrk_word),
    .chk_vld   (chk_vld),
    .chk_word  (chk_word),
    .maint_clr (maint_clr),
    .safe_word (safe_word),
    .err_pulse (err_pulse),
    .silent    (silent),
    .cmp_fault (cmp_fault),
    .test_cyc  (st_hit)
);

// File: tb/lsc_gate_bench.sv
module lsc_gate_bench;

    localparam int unsigned W    = 16;
    localparam int unsigned SKEW = 2;
    localparam int unsigned TPER = 16;
    localparam logic [15:0] SAFE = 16'h0BAD;

    typedef struct packed {
        logic        wv;
        logic [15:0] wd;
        logic        cv;
        logic [15:0] cd;
        logic        clr;
        logic [15:0] eo;
        logic        ee;
        logic        es;
        logic        ec;
        logic [3:0]  rq;
    } vec_t;

    // Index i is applied on clock edge i after reset release.
    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 16'h1111, 1'b1, 16'h1111, 1'b0, 16'h1111, 1'b0, 1'b0, 1'b0, 4'd1}, // R1
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h1111, 1'b0, 1'b0, 1'b0, 4'd2}, // R2
        '{1'b1, 16'h2222, 1'b1, 16'h2222, 1'b0, 16'h2222, 1'b0, 1'b0, 1'b0, 4'd1}, // R1
        '{1'b1, 16'h3333, 1'b0, 16'h0000, 1'b0, 16'h2222, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 lone 1
        '{1'b1, 16'h3333, 1'b0, 16'h0000, 1'b0, 16'h2222, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 lone 2
        '{1'b1, 16'h3333, 1'b1, 16'h3333, 1'b0, 16'h3333, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 late partner
        '{1'b1, 16'h4444, 1'b1, 16'h4445, 1'b0, SAFE,     1'b1, 1'b1, 1'b0, 4'd3}, // R3
        '{1'b1, 16'h5555, 1'b1, 16'h5555, 1'b0, SAFE,     1'b0, 1'b1, 1'b0, 4'd4}, // R4
        '{1'b1, 16'h6666, 1'b1, 16'h6667, 1'b1, SAFE,     1'b1, 1'b1, 1'b0, 4'd5}, // R5 clr+disagree
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, SAFE,     1'b0, 1'b1, 1'b0, 4'd5}, // R5 clr, no compare
        '{1'b1, 16'h7777, 1'b1, 16'h7777, 1'b1, 16'h7777, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 clr honoured
        '{1'b1, 16'h8888, 1'b1, 16'h8888, 1'b0, 16'h8888, 1'b0, 1'b0, 1'b0, 4'd1},
        '{1'b1, 16'h9999, 1'b1, 16'h9999, 1'b0, 16'h9999, 1'b0, 1'b0, 1'b0, 4'd1},
        '{1'b1, 16'hAAAA, 1'b1, 16'hAAAA, 1'b0, 16'hAAAA, 1'b0, 1'b0, 1'b0, 4'd1},
        '{1'b1, 16'hBBBB, 1'b1, 16'hBBBB, 1'b0, 16'hBBBB, 1'b0, 1'b0, 1'b0, 4'd1},
        '{1'b1, 16'hCCCC, 1'b1, 16'hCCCD, 1'b0, 16'hBBBB, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 test cycle
        '{1'b1, 16'hCCCC, 1'b1, 16'hCCCC, 1'b0, 16'hCCCC, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 no cmp fault
        '{1'b0, 16'h0000, 1'b1, 16'h1234, 1'b0, 16'hCCCC, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, 16'h0000, 1'b1, 16'h1234, 1'b0, 16'hCCCC, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, 16'h0000, 1'b1, 16'h1234, 1'b0, SAFE,     1'b1, 1'b1, 1'b0, 4'd6}, // R6 timeout
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, SAFE,     1'b0, 1'b1, 1'b0, 4'd4},
        '{1'b1, 16'h1234, 1'b1, 16'h1234, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, 4'd5},
        '{1'b1, 16'h4321, 1'b1, 16'h4321, 1'b0, 16'h4321, 1'b0, 1'b0, 1'b0, 4'd1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wrk_vld = 1'b0;
    logic [W-1:0]  wrk_word = '0;
    logic          chk_vld = 1'b0;
    logic [W-1:0]  chk_word = '0;
    logic          maint_clr = 1'b0;
    logic [W-1:0]  safe_word;
    logic          err_pulse;
    logic          silent;
    logic          cmp_fault;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lsc_gate #(
        .W(W), .SKEW_MAX(SKEW), .TEST_PERIOD(TPER), .SAFE_VAL(SAFE)
    ) u_lsc_gate (
        .clk(clk), .rst(rst),
        .wrk_vld(wrk_vld), .wrk_word(wrk_word),
        .chk_vld(chk_vld), .chk_word(chk_word),
        .maint_clr(maint_clr),
        .safe_word(safe_word), .err_pulse(err_pulse),
        .silent(silent), .cmp_fault(cmp_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wv, input logic [15:0] wd, input logic cv,
                         input logic [15:0] cd, input logic clr);
        wrk_vld = wv; wrk_word = wd; chk_vld = cv; chk_word = cd; maint_clr = clr;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run state actual hung expected finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: state after reset
        chk("R9 reset safe_word", 32'(safe_word), 32'(SAFE));
        chk("R9 reset silent", 32'(silent), 0);
        chk("R9 reset err_pulse", 32'(err_pulse), 0);
        chk("R9 reset cmp_fault", 32'(cmp_fault), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].wv, TBL[i].wd, TBL[i].cv, TBL[i].cd, TBL[i].clr);
            @(negedge clk);
            chk($sformatf("R%0d vec %0d safe_word", TBL[i].rq, i), 32'(safe_word), 32'(TBL[i].eo));
            chk($sformatf("R%0d vec %0d err_pulse", TBL[i].rq, i), 32'(err_pulse), 32'(TBL[i].ee));
            chk($sformatf("R%0d vec %0d silent", TBL[i].rq, i), 32'(silent), 32'(TBL[i].es));
            chk($sformatf("R%0d vec %0d cmp_fault", TBL[i].rq, i), 32'(cmp_fault), 32'(TBL[i].ec));
        end

        // R3 then R9: reset clears a fresh fault
        drive(1'b1, 16'hAAAA, 1'b1, 16'h5555, 1'b0);
        @(negedge clk);
        chk("R3 directed silent", 32'(silent), 1);
        drive(1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 mid-run reset safe_word", 32'(safe_word), 32'(SAFE));
        chk("R9 mid-run reset silent", 32'(silent), 0);
        chk("R9 mid-run reset err_pulse", 32'(err_pulse), 0);
        rst = 1'b0;

        // R9: self-test counter restarts, so index 15 is again the test cycle (R7)
        for (int k = 0; k < 15; k++) begin
            drive(1'b1, 16'h7E00 + 16'(k), 1'b1, 16'h7E00 + 16'(k), 1'b0);
            @(negedge clk);
        end
        chk("R1 after reset pass", 32'(safe_word), 32'h7E0E);
        drive(1'b1, 16'hF00D, 1'b1, 16'hF00D, 1'b0);
        @(negedge clk);
        chk("R7 restarted test cycle holds", 32'(safe_word), 32'h7E0E);
        chk("R8 comparator healthy", 32'(cmp_fault), 0);
        drive(1'b1, 16'hF00D, 1'b1, 16'hF00D, 1'b0);
        @(negedge clk);
        chk("R1 after test cycle", 32'(safe_word), 32'hF00D);

        summary();
    end
endmodule